// File: doc/BRIEF.md
# Port-Programmed Byte Copy Engine

This block copies a run of bytes from one memory location to another on behalf of a small 8-bit processor. The processor sets the block up through fourteen consecutive I/O ports. Each address is five bytes wide: a 16-bit offset inside a bank, one spare byte, and two bank-select bytes. The remaining ports hold a 16-bit length-minus-one counter, a mode byte and a command byte. Writing a set bit 0 to the command port starts the copy. The block then drives its own byte-wide memory port. For each byte it issues a read handshake at the source, followed by a write handshake at the destination.

The two bank-select bytes of the address in use are decoded into a region code, which goes out beside the 16-bit offset. Only the plain-copy mode (0xC0) moves data, and it increments both offsets after each byte. Any other mode turns a start into a no-operation. Bit 0 of the command port reads as the busy flag. While the block is busy, the register file is locked against writes. A second controller is made by instantiating the block again with a different base port.

Top module: `iocopy_dma`

## Requirements
- R1: After reset every register reads 0x00, `busy` is 0 and neither `mem_rd_req` nor `mem_wr_req` is asserted.
- R2: Port offsets from `BASE_PORT` are laid out as follows: 0..4 source bytes 0..4, 5..9 destination bytes 0..4, 10 counter low, 11 counter high, 12 mode, 13 command. Each port reads back the value last written to it. The command port reads `{7'b0, busy}`. Ports outside this window read 0x00, and writes to them change nothing.
- R3: A write with bit 0 set to the command port, made while idle with mode 0xC0, raises `busy` and `mem_rd_req` in the following cycle.
- R4: The read request holds until `mem_rd_ack`. The next cycle raises `mem_wr_req` with `mem_wdata` equal to the `mem_rdata` captured at the acknowledge. This request holds until `mem_wr_ack`. The two requests are never active together.
- R5: Every `mem_wr_ack` adds one to both 16-bit offsets, wrapping 0xFFFF to 0x0000, and leaves the bank bytes unchanged. It also subtracts one from the counter.
- R6: The copy ends with the byte moved while the counter is 0, so counter+1 bytes move in total. `busy` falls in the cycle after that final `mem_wr_ack`. The counter then reads 0xFFFF and the offsets read their post-increment values.
- R7: While `busy`, writes to every port are ignored, including the command port.
- R8: If the mode is not 0xC0, a start leaves `busy` at 0 and issues no memory request.
- R9: `mem_addr` carries the source offset during a read request and the destination offset during a write request.
- R10: The region code is decoded from bank bytes b3 and b4 of the address in use, in this priority order:
  - b3=0x84 gives 1.
  - b3=0x88 gives 2.
  - b3=0x00 with b4=0x80 gives 3.
  - b3=0x40 with b4[3:0]=0x7 gives 4.
  - With b3=0x40, b4[4:2] selects the rest: 101 gives 5, 001 gives 6, 100 gives 7, 000 gives 8.
  - Anything else gives 0, and the copy still runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 8 | I/O port address |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data for `io_addr` (combinational) |
| busy | output | 1 | Copy in progress |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_ack | input | 1 | Read data valid |
| mem_rdata | input | 8 | Memory read data |
| mem_wr_req | output | 1 | Memory write request |
| mem_wr_ack | input | 1 | Write accepted |
| mem_wdata | output | 8 | Memory write data |
| mem_addr | output | 16 | In-bank offset |
| mem_region | output | 4 | Decoded region code |

## Verification
`io_rdata`, `mem_addr` and `mem_region` are combinational and are due in the same cycle as the address or request they follow. A command write raises the read request one clock later. Each acknowledge moves the request to the other phase at the next clock. After the final write acknowledge, `busy` falls and the registers show their advanced values one clock later. The bench's behavioural model advances on the same edges as the design, and every output is compared against it at the falling edge, half a period after each update. The bench's memory responder also verifies the destination bytes at the end of each copy.

// File: rtl/iocopy_pkg.sv
package iocopy_pkg;
  localparam logic [7:0] MODE_COPY = 8'hC0;

  typedef enum logic [3:0] {
    RGN_NONE     = 4'd0,
    RGN_FLASH0   = 4'd1,
    RGN_FLASH1   = 4'd2,
    RGN_SCRATCH0 = 4'd3,
    RGN_SCRATCH1 = 4'd4,
    RGN_DATA_HI  = 4'd5,
    RGN_DATA_LO  = 4'd6,
    RGN_CODE_HI  = 4'd7,
    RGN_CODE_LO  = 4'd8
  } region_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_STORE = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/iocopy_bankdec.sv
module iocopy_bankdec
  import iocopy_pkg::*;
(
  input  logic [7:0] sel_hi,   // bank byte 3
  input  logic [7:0] sel_top,  // bank byte 4
  output region_e    region
);
  always_comb begin
    region = RGN_NONE;
    if (sel_hi == 8'h84) begin
      region = RGN_FLASH0;
    end else if (sel_hi == 8'h88) begin
      region = RGN_FLASH1;
    end else if (sel_hi == 8'h00 && sel_top == 8'h80) begin
      region = RGN_SCRATCH0;
    end else if (sel_hi == 8'h40) begin
      // low-nibble 7 pattern overlaps the 3'b001 field, so it wins first (R10)
      if (sel_top[3:0] == 4'h7) begin
        region = RGN_SCRATCH1;
      end else begin
        unique case (sel_top[4:2])
          3'b101:  region = RGN_DATA_HI;
          3'b001:  region = RGN_DATA_LO;
          3'b100:  region = RGN_CODE_HI;
          3'b000:  region = RGN_CODE_LO;
          default: region = RGN_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/iocopy_regs.sv
module iocopy_regs #(
  parameter int BASE_PORT  = 6,
  parameter int ADDR_BYTES = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  io_addr,
  input  logic        io_wr,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  input  logic        busy_i,
  input  logic        step_i,
  output logic        start_o,
  output logic        last_o,
  output logic [7:0]  mode_o,
  output logic [15:0] src_off_o,
  output logic [15:0] dst_off_o,
  output logic [7:0]  src_b3_o,
  output logic [7:0]  src_b4_o,
  output logic [7:0]  dst_b3_o,
  output logic [7:0]  dst_b4_o
);
  localparam int IW = $clog2(ADDR_BYTES);
  localparam logic [7:0] BASE_P  = BASE_PORT[7:0];
  localparam logic [7:0] DST_P   = ADDR_BYTES[7:0];
  localparam logic [7:0] CLO_P   = DST_P + DST_P;
  localparam logic [7:0] CHI_P   = CLO_P + 8'd1;
  localparam logic [7:0] MODE_P  = CLO_P + 8'd2;
  localparam logic [7:0] CMD_P   = CLO_P + 8'd3;
  localparam logic [7:0] WIN_P   = CLO_P + 8'd4;

  logic [ADDR_BYTES-1:0][7:0] src_q, src_d, dst_q, dst_d;
  logic [15:0] cnt_q, cnt_d;
  logic [7:0]  mode_q, mode_d;
  logic [7:0]  off, doff;
  logic        in_win, wr_ok;

  assign off    = io_addr - BASE_P;
  assign doff   = off - DST_P;
  assign in_win = (io_addr >= BASE_P) && (off < WIN_P);
  assign wr_ok  = io_wr && in_win && !busy_i;

  assign start_o   = wr_ok && (off == CMD_P) && io_wdata[0];
  assign last_o    = (cnt_q == 16'd0);
  assign mode_o    = mode_q;
  assign src_off_o = {src_q[1], src_q[0]};
  assign dst_off_o = {dst_q[1], dst_q[0]};
  assign src_b3_o  = src_q[3];
  assign src_b4_o  = src_q[4];
  assign dst_b3_o  = dst_q[3];
  assign dst_b4_o  = dst_q[4];

  // next state
  always_comb begin
    src_d  = src_q;
    dst_d  = dst_q;
    cnt_d  = cnt_q;
    mode_d = mode_q;
    if (step_i) begin
      {src_d[1], src_d[0]} = {src_q[1], src_q[0]} + 16'd1;
      {dst_d[1], dst_d[0]} = {dst_q[1], dst_q[0]} + 16'd1;
      cnt_d = cnt_q - 16'd1;
    end else if (wr_ok) begin
      if (off < DST_P)       src_d[off[IW-1:0]]  = io_wdata;
      else if (off < CLO_P)  dst_d[doff[IW-1:0]] = io_wdata;
      else if (off == CLO_P) cnt_d[7:0]  = io_wdata;
      else if (off == CHI_P) cnt_d[15:8] = io_wdata;
      else if (off == MODE_P) mode_d = io_wdata;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      mode_q <= '0;
    end else begin
      src_q  <= src_d;
      dst_q  <= dst_d;
      cnt_q  <= cnt_d;
      mode_q <= mode_d;
    end
  end

  // read-back
  always_comb begin
    io_rdata = 8'h00;
    if (in_win) begin
      if (off < DST_P)        io_rdata = src_q[off[IW-1:0]];
      else if (off < CLO_P)   io_rdata = dst_q[doff[IW-1:0]];
      else if (off == CLO_P)  io_rdata = cnt_q[7:0];
      else if (off == CHI_P)  io_rdata = cnt_q[15:8];
      else if (off == MODE_P) io_rdata = mode_q;
      else                    io_rdata = {7'd0, busy_i};
    end
  end

  p_step_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> src_off_o == $past(src_off_o) + 16'd1);
  p_step_cnt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> cnt_q == $past(cnt_q) - 16'd1);
  p_bank_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> $stable(src_b3_o) && $stable(dst_b4_o));
  p_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !step_i) |=> $stable(src_q) && $stable(dst_q) && $stable(cnt_q) && $stable(mode_q));
endmodule

// File: rtl/iocopy_engine.sv
module iocopy_engine
  import iocopy_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] mode_i,
  input  logic       last_i,
  input  logic       rd_ack_i,
  input  logic [7:0] rd_data_i,
  input  logic       wr_ack_i,
  output logic       busy_o,
  output logic       rd_req_o,
  output logic       wr_req_o,
  output logic [7:0] wr_data_o,
  output logic       step_o
);
  xfer_state_e st_q, st_d;
  logic [7:0]  hold_q, hold_d;
  logic        mode_ok;

  assign mode_ok   = (mode_i == MODE_COPY);
  assign busy_o    = (st_q != ST_IDLE);
  assign rd_req_o  = (st_q == ST_FETCH);
  assign wr_req_o  = (st_q == ST_STORE);
  assign wr_data_o = hold_q;
  assign step_o    = (st_q == ST_STORE) && wr_ack_i;

  always_comb begin
    st_d   = st_q;
    hold_d = hold_q;
    unique case (st_q)
      ST_IDLE:  if (start_i && mode_ok) st_d = ST_FETCH;
      ST_FETCH: if (rd_ack_i) begin
                  hold_d = rd_data_i;
                  st_d   = ST_STORE;
                end
      ST_STORE: if (wr_ack_i) st_d = last_i ? ST_IDLE : ST_FETCH;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      hold_q <= '0;
    end else begin
      st_q   <= st_d;
      hold_q <= hold_d;
    end
  end

  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && mode_ok) |=> rd_req_o);
  p_rw_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_o && wr_req_o));
  p_rd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_ack_i) |=> rd_req_o);
  p_fetch_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && rd_ack_i) |=> wr_req_o && wr_data_o == $past(rd_data_i));
  p_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_o && wr_ack_i && last_i) |=> !busy_o);
  p_noop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && !mode_ok) |=> !busy_o);
endmodule

// File: rtl/iocopy_dma.sv
module iocopy_dma
  import iocopy_pkg::*;
#(
  parameter int BASE_PORT  = 6,
  parameter int ADDR_BYTES = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  io_addr,
  input  logic        io_wr,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  output logic        busy,
  output logic        mem_rd_req,
  input  logic        mem_rd_ack,
  input  logic [7:0]  mem_rdata,
  output logic        mem_wr_req,
  input  logic        mem_wr_ack,
  output logic [7:0]  mem_wdata,
  output logic [15:0] mem_addr,
  output logic [3:0]  mem_region
);
  logic        rst_meta, rst_sn;
  logic        start, last, step;
  logic [7:0]  mode;
  logic [15:0] src_off, dst_off;
  logic [7:0]  sb3, sb4, db3, db4;
  region_e     src_rgn, dst_rgn;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sn   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sn   <= rst_meta;
    end
  end

  iocopy_regs #(.BASE_PORT(BASE_PORT), .ADDR_BYTES(ADDR_BYTES)) u_regs (
    .clk(clk), .rst_n(rst_sn),
    .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .busy_i(busy), .step_i(step), .start_o(start), .last_o(last), .mode_o(mode),
    .src_off_o(src_off), .dst_off_o(dst_off),
    .src_b3_o(sb3), .src_b4_o(sb4), .dst_b3_o(db3), .dst_b4_o(db4)
  );

  iocopy_engine u_eng (
    .clk(clk), .rst_n(rst_sn),
    .start_i(start), .mode_i(mode), .last_i(last),
    .rd_ack_i(mem_rd_ack), .rd_data_i(mem_rdata), .wr_ack_i(mem_wr_ack),
    .busy_o(busy), .rd_req_o(mem_rd_req), .wr_req_o(mem_wr_req),
    .wr_data_o(mem_wdata), .step_o(step)
  );

  iocopy_bankdec u_src_dec (.sel_hi(sb3), .sel_top(sb4), .region(src_rgn));
  iocopy_bankdec u_dst_dec (.sel_hi(db3), .sel_top(db4), .region(dst_rgn));

  assign mem_addr   = mem_wr_req ? dst_off : src_off;
  assign mem_region = mem_wr_req ? dst_rgn : src_rgn;

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    !busy |-> !mem_rd_req && !mem_wr_req);
  p_addr_phase_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_rd_req |-> mem_addr == src_off);
endmodule

// File: tb/sim_iocopy_dma.sv
`timescale 1ns/1ps
module sim_iocopy_dma;
  localparam int BASE = 6;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] io_addr = 8'd0, io_wdata = 8'd0, io_rdata;
  logic io_wr = 1'b0;
  logic busy, mem_rd_req, mem_wr_req;
  logic mem_rd_ack = 1'b0, mem_wr_ack = 1'b0;
  logic [7:0] mem_rdata = 8'd0, mem_wdata;
  logic [15:0] mem_addr;
  logic [3:0] mem_region;

  int checks = 0, failures = 0, lat = 0, wcnt = 0;
  byte unsigned mem [int];

  // behavioural model
  int m_st = 0;
  byte unsigned m_src [5], m_dst [5], m_mode = 0, m_hold = 0;
  int m_cnt = 0;

  always #10 clk = ~clk;

  iocopy_dma #(.BASE_PORT(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .busy(busy), .mem_rd_req(mem_rd_req), .mem_rd_ack(mem_rd_ack),
    .mem_rdata(mem_rdata), .mem_wr_req(mem_wr_req), .mem_wr_ack(mem_wr_ack),
    .mem_wdata(mem_wdata), .mem_addr(mem_addr), .mem_region(mem_region)
  );

  function automatic int rgn(byte unsigned b3, byte unsigned b4);
    if (b3 == 8'h84) return 1;
    if (b3 == 8'h88) return 2;
    if (b3 == 8'h00) return (b4 == 8'h80) ? 3 : 0;
    if (b3 != 8'h40) return 0;
    if ((b4 & 8'h0F) == 8'h07) return 4;
    case ((b4 >> 2) & 8'h07)
      5: return 5;
      1: return 6;
      4: return 7;
      0: return 8;
      default: return 0;
    endcase
  endfunction

  function automatic byte unsigned memrd(int key);
    if (mem.exists(key)) return mem[key];
    return byte'((key * 37 + 11) & 255);
  endfunction

  function automatic int exp_io(byte unsigned a);
    int o;
    o = int'(a) - BASE;
    if (o < 0 || o > 13) return 0;
    if (o < 5) return m_src[o];
    if (o < 10) return m_dst[o - 5];
    if (o == 10) return m_cnt & 255;
    if (o == 11) return (m_cnt >> 8) & 255;
    if (o == 12) return m_mode;
    return (m_st != 0) ? 1 : 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // model update on the same edge as the design
  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_mode = 0; m_hold = 0;
      for (int i = 0; i < 5; i++) begin m_src[i] = 0; m_dst[i] = 0; end
    end else begin
      case (m_st)
        0: if (io_wr) begin
             int o;
             o = int'(io_addr) - BASE;
             if (o >= 0 && o < 5) m_src[o] = io_wdata;
             else if (o >= 5 && o < 10) m_dst[o - 5] = io_wdata;
             else if (o == 10) m_cnt = (m_cnt & 16'hFF00) | io_wdata;
             else if (o == 11) m_cnt = (m_cnt & 16'h00FF) | (int'(io_wdata) << 8);
             else if (o == 12) m_mode = io_wdata;
             else if (o == 13 && io_wdata[0] && m_mode == 8'hC0) m_st = 1;
           end
        1: if (mem_rd_ack) begin m_hold = mem_rdata; m_st = 2; end
        default: if (mem_wr_ack) begin
             int s, d;
             s = ((m_src[1] << 8) | m_src[0]) + 1;
             d = ((m_dst[1] << 8) | m_dst[0]) + 1;
             m_src[0] = s[7:0]; m_src[1] = s[15:8];
             m_dst[0] = d[7:0]; m_dst[1] = d[15:8];
             m_st = (m_cnt == 0) ? 0 : 1;
             m_cnt = (m_cnt - 1) & 16'hFFFF;
           end
      endcase
    end
  end

  // compare every cycle, then act as the memory
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 busy", busy, m_st != 0);
      chk("R4 rd_req", mem_rd_req, m_st == 1);
      chk("R4 wr_req", mem_wr_req, m_st == 2);
      chk("R2 io_rdata", io_rdata, exp_io(io_addr));
      if (m_st == 1) begin
        chk("R9 src addr", mem_addr, (m_src[1] << 8) | m_src[0]);
        chk("R10 src region", mem_region, rgn(m_src[3], m_src[4]));
      end
      if (m_st == 2) begin
        chk("R9 dst addr", mem_addr, (m_dst[1] << 8) | m_dst[0]);
        chk("R10 dst region", mem_region, rgn(m_dst[3], m_dst[4]));
        chk("R4 wdata", mem_wdata, m_hold);
      end
    end
    #1;
    mem_rd_ack = 1'b0; mem_wr_ack = 1'b0;
    if (!rst_n) wcnt = 0;
    else if (mem_rd_req || mem_wr_req) begin
      if (wcnt >= lat) begin
        wcnt = 0;
        if (mem_rd_req) begin
          mem_rd_ack = 1'b1;
          mem_rdata = memrd(int'(mem_region) * 65536 + int'(mem_addr));
        end else begin
          mem_wr_ack = 1'b1;
          mem[int'(mem_region) * 65536 + int'(mem_addr)] = mem_wdata;
        end
      end else wcnt++;
    end
  end

  task automatic io_write(input int a, input int d);
    @(negedge clk); #2;
    io_addr = a[7:0]; io_wdata = d[7:0]; io_wr = 1'b1;
    @(negedge clk); #2;
    io_wr = 1'b0;
  endtask

  task automatic read_expect(input int a, input int exp, input string tag);
    @(negedge clk); #2;
    io_addr = a[7:0];
    @(negedge clk); #2;
    chk(tag, io_rdata, exp);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask

  task automatic run_copy(input int so, input int s3, input int s4,
                          input int d_o, input int d3, input int d4,
                          input int len, input int l, input bit wait_done = 1);
    int sk, dk;
    lat = l;
    sk = rgn(byte'(s3), byte'(s4)) * 65536;
    dk = rgn(byte'(d3), byte'(d4)) * 65536;
    io_write(BASE + 0, so & 255);  io_write(BASE + 1, so >> 8);
    io_write(BASE + 2, 0);         io_write(BASE + 3, s3); io_write(BASE + 4, s4);
    io_write(BASE + 5, d_o & 255); io_write(BASE + 6, d_o >> 8);
    io_write(BASE + 7, 0);         io_write(BASE + 8, d3); io_write(BASE + 9, d4);
    io_write(BASE + 10, (len - 1) & 255); io_write(BASE + 11, ((len - 1) >> 8) & 255);
    io_write(BASE + 12, 8'hC0);
    begin
      byte unsigned expv [$];
      for (int i = 0; i < len; i++) expv.push_back(memrd(sk + ((so + i) & 16'hFFFF)));
      io_write(BASE + 13, 1);
      if (wait_done) begin
        wait_idle();
        for (int i = 0; i < len; i++)
          chk("R6 copied byte", memrd(dk + ((d_o + i) & 16'hFFFF)), expv[i]);
      end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 req", mem_rd_req | mem_wr_req, 0);
    for (int a = BASE; a < BASE + 14; a++) read_expect(a, 0, "R1 reg");

    // R2 window edges
    io_write(BASE + 14, 8'h5A);
    read_expect(BASE + 14, 0, "R2 outside high");
    io_write(BASE - 1, 8'h5A);
    read_expect(BASE - 1, 0, "R2 outside low");
    io_write(BASE + 2, 8'h3C);
    read_expect(BASE + 2, 8'h3C, "R2 spare byte");

    // R3 R4 R5 R6 basic copies, different latencies and regions
    run_copy(16'h0010, 8'h00, 8'h80, 16'h0200, 8'h40, 8'h00, 4, 0);
    read_expect(BASE + 10, 8'hFF, "R6 count lo");
    read_expect(BASE + 11, 8'hFF, "R6 count hi");
    read_expect(BASE + 0, 8'h14, "R5 src lo");
    read_expect(BASE + 5, 8'h04, "R5 dst lo");
    read_expect(BASE + 13, 0, "R6 cmd idle");
    run_copy(16'h1234, 8'h84, 8'h00, 16'h0000, 8'h88, 8'h00, 1, 2);
    run_copy(16'h0300, 8'h40, 8'h14, 16'h0100, 8'h40, 8'h04, 7, 1);

    // R5 offset wrap, bank bytes kept
    run_copy(16'hFFFF, 8'h40, 8'h10, 16'hFFFE, 8'h40, 8'h07, 3, 0);
    read_expect(BASE + 1, 8'h00, "R5 src wrap hi");
    read_expect(BASE + 0, 8'h02, "R5 src wrap lo");
    read_expect(BASE + 8, 8'h40, "R5 bank kept");

    // R10 unmapped region still moves data
    run_copy(16'h0040, 8'h12, 8'h34, 16'h0050, 8'h40, 8'h18, 2, 1);

    // R7 writes ignored while busy
    run_copy(16'h0020, 8'h00, 8'h80, 16'h0600, 8'h40, 8'h00, 6, 3, 0);
    io_write(BASE + 0, 8'hAA);
    io_write(BASE + 10, 8'h55);
    io_write(BASE + 12, 8'h00);
    io_write(BASE + 13, 8'h01);
    wait_idle();
    read_expect(BASE + 0, 8'h26, "R7 src kept");
    read_expect(BASE + 10, 8'hFF, "R7 count kept");
    read_expect(BASE + 12, 8'hC0, "R7 mode kept");

    // R8 non-copy mode is a no-op
    io_write(BASE + 12, 8'h80);
    io_write(BASE + 13, 8'h01);
    chk("R8 no busy", busy, 0);
    read_expect(BASE + 13, 0, "R8 cmd reads 0");
    chk("R8 no request", mem_rd_req | mem_wr_req, 0);

    repeat (4) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule